// File: doc/BRIEF.md
# Iterative Carry-Less Divider

This unit divides one unsigned polynomial over GF(2) by another using XOR-based long division. Both operands are N-bit vectors, where bit i is the coefficient of x^i. The unit returns an N-bit quotient and an N-bit remainder, which satisfy dividend = quotient ⊗ divisor ⊕ remainder, where ⊗ is carry-less multiplication. The remainder always has a lower degree than the divisor.

The parameter S sets how many one-bit division steps are chained combinationally in each clock. A single design therefore covers everything from fully serial operation (S = 1) to a result one cycle after acceptance (S ≥ N). Only one operation is in flight at a time.

Operands enter through a valid/ready handshake and results leave through a second valid/ready handshake. The input side never pushes back while idle. It holds `in_ready` low from acceptance until the result has been taken. The output side holds its result and `out_valid` for as long as the consumer keeps `out_ready` low, and it does not drop the result.

Top module: `cldr_unit`

## Requirements
- R1: A synchronous active-high `rst` puts the unit in idle: after a clock edge with `rst` high, `in_ready` is 1 and `out_valid` is 0.
- R2: An operation is accepted at a rising edge where `in_valid` and `in_ready` are both 1. In the cycle after that edge, `in_ready` and `out_valid` are both 0.
- R3: `out_valid` rises exactly ceil(N/S) clock cycles after the acceptance edge.
- R4: Any change to `in_valid`, `in_dividend` or `in_divisor` after acceptance, and before the unit returns to idle, has no effect on the result delivered.
- R5: When the divisor is non-zero, `out_quot` and `out_rem` are the carry-less quotient and remainder. The quotient has bit i set for each shift of the divisor that long division XORs into the dividend.
- R6: When the divisor is non-zero, the remainder has no bit set at or above the position of the divisor's highest set bit.
- R7: While `out_valid` is 1 and `out_ready` is 0, `out_valid`, `out_quot` and `out_rem` hold their values from cycle to cycle, and `in_ready` stays 0.
- R8: In the cycle after an edge where `out_valid` and `out_ready` are both 1, `in_ready` is 1 and `out_valid` is 0.
- R9: A zero divisor still completes both handshakes with the timing of R3. The result values in that case are not defined.
- R10: When S is at least N, `out_valid` rises one cycle after the acceptance edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operand pair offered |
| in_ready | output | 1 | Unit idle and able to take an operand pair |
| in_dividend | input | N | Dividend polynomial |
| in_divisor | input | N | Divisor polynomial |
| out_valid | output | 1 | Result available |
| out_ready | input | 1 | Consumer takes the result |
| out_quot | output | N | Quotient polynomial |
| out_rem | output | N | Remainder polynomial |

## Verification
The bench builds the unit with N=4 and every S from 1 to 4. With N=6 and S=10, it covers the case where the whole division fits in one clock. At these sizes every dividend/divisor pair, including the zero divisor, is driven through both handshakes. N=8 with S=3 and N=32 with S=5 take pseudo-random operands plus extreme divisors (1 and the top bit alone). In these builds the final clock runs fewer than S steps, which exercises the gating of the unused chained stages. Random back-pressure and operand noise during the busy period are applied throughout.

// File: rtl/cldr_pkg.sv
package cldr_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_BUSY = 2'd1,
    ST_DONE = 2'd2
  } cldr_state_e;

  // Number of clocks spent chaining division steps for n steps at s per clock.
  function automatic int busy_clocks(input int n, input int s);
    return (n + s - 1) / s;
  endfunction

endpackage

// File: rtl/cldr_lead_one.sv
// Isolates the highest set bit of a vector; all zeros in gives all zeros out.
module cldr_lead_one #(
  parameter int N = 8
) (
  input  logic [N-1:0] vec,
  output logic [N-1:0] top
);

  logic [N-1:0] higher_set;

  assign higher_set[N-1] = 1'b0;

  for (genvar i = 0; i < N - 1; i++) begin : g_scan
    assign higher_set[i] = |vec[N-1:i+1];
  end

  assign top = vec & ~higher_set;

endmodule

// File: rtl/cldr_step.sv
// One carry-less long-division step: shift the next dividend bit into the
// partial remainder and cancel the divisor's leading term when it appears.
module cldr_step #(
  parameter int N = 8
) (
  input  logic         en,
  input  logic [N-1:0] nq_i,    // upper: dividend bits left, lower: quotient so far
  input  logic [N-1:0] rem_i,
  input  logic [N-1:0] div_i,
  input  logic [N-1:0] mask_i,  // one-hot leading term of the divisor
  output logic [N-1:0] nq_o,
  output logic [N-1:0] rem_o
);

  logic [N-1:0] rem_sh;
  logic         hit;

  assign rem_sh = {rem_i[N-2:0], nq_i[N-1]};
  assign hit    = |({rem_i, nq_i[N-1]} & {1'b0, mask_i});

  always_comb begin
    if (en) begin
      rem_o = hit ? (rem_sh ^ div_i) : rem_sh;
      nq_o  = {nq_i[N-2:0], hit};
    end else begin
      rem_o = rem_i;
      nq_o  = nq_i;
    end
  end

endmodule

// File: rtl/cldr_ctrl.sv
module cldr_ctrl
  import cldr_pkg::*;
#(
  parameter int N  = 8,
  parameter int S  = 2,
  parameter int CW = $clog2(N + S + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  output logic          in_ready,
  output logic          out_valid,
  input  logic          out_ready,
  output logic          load,
  output logic          advance,
  output logic [CW-1:0] stp
);

  localparam int BUSY_CYC = busy_clocks(N, S);

  cldr_state_e   st_q;
  logic [CW-1:0] stp_q;
  logic [CW-1:0] stp_nx;
  logic [CW-1:0] busy_len_q;

  assign in_ready  = (st_q == ST_IDLE);
  assign out_valid = (st_q == ST_DONE);
  assign load      = in_ready & in_valid;
  assign advance   = (st_q == ST_BUSY);
  assign stp       = stp_q;
  assign stp_nx    = stp_q + CW'(S);

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q  <= ST_IDLE;
      stp_q <= '0;
    end else begin
      case (st_q)
        ST_IDLE: if (in_valid) begin
          st_q  <= ST_BUSY;
          stp_q <= '0;
        end
        ST_BUSY: begin
          stp_q <= stp_nx;
          if (stp_nx >= CW'(N)) st_q <= ST_DONE;
        end
        ST_DONE: if (out_ready) st_q <= ST_IDLE;
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  // Cycle counter from acceptance, used to check the busy window length.
  always_ff @(posedge clk) begin
    if (rst || load) busy_len_q <= '0;
    else if (advance) busy_len_q <= busy_len_q + 1'b1;
  end

  AST_RESET_IDLE: assert property (@(posedge clk)
    rst |=> (in_ready && !out_valid)); // R1
  AST_ACCEPT_BLOCKS: assert property (@(posedge clk) disable iff (rst)
    load |=> (!in_ready && !out_valid)); // R2
  AST_BUSY_LENGTH: assert property (@(posedge clk) disable iff (rst)
    $rose(out_valid) |-> (busy_len_q == CW'(BUSY_CYC))); // R3
  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && !in_ready)); // R7
  AST_RELEASE: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_ready) |=> (in_ready && !out_valid)); // R8

endmodule

// File: rtl/cldr_unit.sv
module cldr_unit #(
  parameter int N = 8,
  parameter int S = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [N-1:0] in_dividend,
  input  logic [N-1:0] in_divisor,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [N-1:0] out_quot,
  output logic [N-1:0] out_rem
);

  localparam int CW = $clog2(N + S + 1);

  logic          load;
  logic          advance;
  logic [CW-1:0] stp;
  logic [N-1:0]  lead_in;
  logic [N-1:0]  nq_q, rem_q, div_q, mask_q;
  logic [N-1:0]  nq_c  [S+1];
  logic [N-1:0]  rem_c [S+1];

  cldr_ctrl #(.N(N), .S(S), .CW(CW)) u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .load      (load),
    .advance   (advance),
    .stp       (stp)
  );

  cldr_lead_one #(.N(N)) u_lead (
    .vec (in_divisor),
    .top (lead_in)
  );

  assign nq_c[0]  = nq_q;
  assign rem_c[0] = rem_q;

  for (genvar j = 0; j < S; j++) begin : g_chain
    logic [CW-1:0] idx;
    logic          en;
    assign idx = stp + CW'(j);
    assign en  = (idx < CW'(N));
    cldr_step #(.N(N)) u_step (
      .en     (en),
      .nq_i   (nq_c[j]),
      .rem_i  (rem_c[j]),
      .div_i  (div_q),
      .mask_i (mask_q),
      .nq_o   (nq_c[j+1]),
      .rem_o  (rem_c[j+1])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      nq_q   <= '0;
      rem_q  <= '0;
      div_q  <= '0;
      mask_q <= '0;
    end else if (load) begin
      nq_q   <= in_dividend;
      rem_q  <= '0;
      div_q  <= in_divisor;
      mask_q <= lead_in;
    end else if (advance) begin
      nq_q  <= nq_c[S];
      rem_q <= rem_c[S];
    end
  end

  assign out_quot = nq_q;
  assign out_rem  = rem_q;

  AST_DIVISOR_HELD: assert property (@(posedge clk) disable iff (rst)
    !in_ready |=> ($stable(div_q) && $stable(mask_q))); // R4
  AST_RESULT_STABLE: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> ($stable(out_quot) && $stable(out_rem))); // R7
  AST_LEAD_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    $onehot0(mask_q)); // R6
  AST_REM_BELOW_DIVISOR: assert property (@(posedge clk) disable iff (rst)
    (out_valid && (mask_q != '0)) |-> (rem_q < mask_q)); // R6

endmodule

// File: tb/cldr_harness.sv
module cldr_harness #(
  parameter int N   = 4,
  parameter int S   = 1,
  parameter int NUM = 0   // 0: every operand pair, otherwise this many random pairs
) (
  input  logic clk,
  input  logic rst,
  input  int   cyc,
  output logic done,
  output int   n_chk,
  output int   n_err
);

  localparam int C = (N + S - 1) / S;

  typedef struct {
    logic [N-1:0] n;
    logic [N-1:0] d;
    int           acc;
  } item_t;

  item_t sb[$];
  int    chk = 0;
  int    err = 0;
  bit    hs_pend = 0;

  logic         in_valid, in_ready, out_valid, out_ready;
  logic [N-1:0] in_dividend, in_divisor, out_quot, out_rem;

  assign n_chk = chk;
  assign n_err = err;

  cldr_unit #(.N(N), .S(S)) uut (
    .clk         (clk),
    .rst         (rst),
    .in_valid    (in_valid),
    .in_ready    (in_ready),
    .in_dividend (in_dividend),
    .in_divisor  (in_divisor),
    .out_valid   (out_valid),
    .out_ready   (out_ready),
    .out_quot    (out_quot),
    .out_rem     (out_rem)
  );

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    chk++;
    if (!ok) begin
      err++;
      $display("FAIL %s N=%0d S=%0d actual=%0h expected=%0h", tag, N, S, act, exp);
    end
  endtask

  function automatic logic [N-1:0] rnd();
    logic [63:0] w;
    w = {$urandom(), $urandom()};
    return w[N-1:0];
  endfunction

  // Software model: textbook polynomial long division over GF(2).
  function automatic void ref_div(input logic [N-1:0] n, input logic [N-1:0] d,
                                  output logic [N-1:0] q, output logic [N-1:0] r,
                                  output int deg);
    deg = -1;
    for (int i = 0; i < N; i++) if (d[i]) deg = i;
    q = '0;
    r = n;
    if (deg >= 0) begin
      for (int i = N - 1; i >= deg; i--) begin
        if (r[i]) begin
          r = r ^ (d << (i - deg));
          q[i - deg] = 1'b1;
        end
      end
    end
  endfunction

  // Driver: offer one pair, then scramble the inputs until the result appears (R4).
  task automatic drive(input logic [N-1:0] n, input logic [N-1:0] d);
    item_t it;
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    in_valid    = 1'b1;
    in_dividend = n;
    in_divisor  = d;
    @(negedge clk);
    it.n = n; it.d = d; it.acc = cyc;
    sb.push_back(it);
    check(!in_ready && !out_valid, "R2", {62'd0, in_ready, out_valid}, 64'd0);
    while (!out_valid) begin
      in_valid    = 1'($urandom() % 2);
      in_dividend = rnd();
      in_divisor  = rnd();
      @(negedge clk);
    end
    in_valid = 1'b0;
  endtask

  initial begin
    in_valid    = 1'b0;
    in_dividend = '0;
    in_divisor  = '0;
    done        = 1'b0;
    @(negedge clk);
    @(negedge clk);
    check(in_ready && !out_valid, "R1", {62'd0, in_ready, out_valid}, 64'd2);
    wait (!rst);
    if (NUM == 0) begin
      for (int a = 0; a < (1 << N); a++)
        for (int b = 0; b < (1 << N); b++)
          drive(N'(a), N'(b));
    end else begin
      drive('1, N'(1));
      drive('1, {1'b1, {(N-1){1'b0}}});
      drive(rnd(), '0);
      drive('1, '1);
      for (int i = 0; i < NUM; i++) drive(rnd(), rnd());
    end
    while (sb.size() != 0 || out_valid || hs_pend) @(negedge clk);
    done = 1'b1;
  end

  // Monitor: pop expected items and compare as results appear.
  initial begin
    bit           seen = 0;
    item_t        it;
    logic [N-1:0] hq, hr, eq, er;
    int           dg;
    string        tag;
    out_ready = 1'b0;
    wait (!rst);
    forever begin
      @(negedge clk);
      if (hs_pend) begin
        check(in_ready && !out_valid, "R8", {62'd0, in_ready, out_valid}, 64'd2);
        hs_pend = 0;
      end
      if (out_valid) begin
        if (!seen) begin
          seen = 1;
          hq = out_quot;
          hr = out_rem;
          if (sb.size() == 0) begin
            check(1'b0, "R2", 64'd0, 64'd1);
          end else begin
            it = sb.pop_front();
            tag = (it.d == '0) ? "R9" : ((S >= N) ? "R10" : "R3");
            check((cyc - it.acc) == C, tag, 64'(cyc - it.acc), 64'(C));
            ref_div(it.n, it.d, eq, er, dg);
            if (it.d != '0) begin
              check(out_quot == eq, "R5", 64'(out_quot), 64'(eq));
              check(out_rem == er, "R5", 64'(out_rem), 64'(er));
              check((out_rem >> dg) == '0, "R6", 64'(out_rem), 64'(er));
            end
          end
        end else begin
          check(out_quot == hq && out_rem == hr && !in_ready, "R7",
                {out_quot, out_rem}, {hq, hr});
        end
        out_ready = ($urandom() % 3) != 0;
        if (out_ready) begin
          seen    = 0;
          hs_pend = 1;
        end
      end else begin
        out_ready = 1'($urandom() % 2);
      end
    end
  end

endmodule

// File: tb/cldr_unit_test.sv
module cldr_unit_test;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  int   cyc = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  logic d0, d1, d2, d3, d4, d5, d6;
  int   c0, c1, c2, c3, c4, c5, c6;
  int   e0, e1, e2, e3, e4, e5, e6;

  cldr_harness #(.N(4),  .S(1),  .NUM(0))   h_n4s1  (.clk(clk), .rst(rst), .cyc(cyc), .done(d0), .n_chk(c0), .n_err(e0));
  cldr_harness #(.N(4),  .S(2),  .NUM(0))   h_n4s2  (.clk(clk), .rst(rst), .cyc(cyc), .done(d1), .n_chk(c1), .n_err(e1));
  cldr_harness #(.N(4),  .S(3),  .NUM(0))   h_n4s3  (.clk(clk), .rst(rst), .cyc(cyc), .done(d2), .n_chk(c2), .n_err(e2));
  cldr_harness #(.N(4),  .S(4),  .NUM(0))   h_n4s4  (.clk(clk), .rst(rst), .cyc(cyc), .done(d3), .n_chk(c3), .n_err(e3));
  cldr_harness #(.N(6),  .S(10), .NUM(0))   h_n6s10 (.clk(clk), .rst(rst), .cyc(cyc), .done(d4), .n_chk(c4), .n_err(e4));
  cldr_harness #(.N(8),  .S(3),  .NUM(400)) h_n8s3  (.clk(clk), .rst(rst), .cyc(cyc), .done(d5), .n_chk(c5), .n_err(e5));
  cldr_harness #(.N(32), .S(5),  .NUM(300)) h_n32s5 (.clk(clk), .rst(rst), .cyc(cyc), .done(d6), .n_chk(c6), .n_err(e6));

  initial begin
    int checks;
    int errors;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    while (!(d0 && d1 && d2 && d3 && d4 && d5 && d6) && cyc < WATCHDOG) @(negedge clk);
    checks = c0 + c1 + c2 + c3 + c4 + c5 + c6;
    errors = e0 + e1 + e2 + e3 + e4 + e5 + e6;
    if (cyc >= WATCHDOG) begin
      checks++;
      errors++;
      $display("FAIL watchdog R3 actual=%0d expected<%0d", cyc, WATCHDOG);
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule